// File: doc/BRIEF.md
# Two-Level Interrupt Aggregation Controller

This block gathers single-cycle event pulses from several circuit sub-blocks and turns them into one active-low interrupt request for a host. Each event sets a sticky secondary status bit. The secondary bits are arranged in groups, one group per sub-block. Each group forms one primary interrupt bit, which is the OR of the group's secondary bits that are not masked. The primary bits that are enabled by a second mask tier then drive the request pin. The pin passes through a global mask and supports either push-pull or open-drain drive.

The host works through a simple synchronous register port with address, write data, write enable and read data. The read path is combinational from the address. The host reads the primary status to find which groups are active. It then reads those groups' secondary status and clears the handled bits by writing 1s. The pin logic is a small state machine with three states:

- `PIN_IDLE`: no enabled request.
- `PIN_ACTIVE`: request asserted.
- `PIN_GATED`: the global mask holds the pin deasserted.

Every cycle the machine picks its next state by priority:

- It goes to `PIN_GATED` whenever the global mask is set. This is the gate transition.
- Otherwise it goes to `PIN_ACTIVE` when any enabled primary is set. This is the raise transition.
- Otherwise it goes to `PIN_IDLE`. This is the drop transition. Leaving `PIN_GATED` is the ungate transition, and it lands on `PIN_ACTIVE` or `PIN_IDLE` by the same rule.

Top module: `irq_aggregator`

## Requirements
- R1: A secondary status bit becomes 1 in the cycle after its event pulse, and it stays 1 after the pulse ends until it is cleared.
- R2: Writing 1 to a bit of a secondary status word (addresses 0 to 3, one per group) clears that bit. Writing 0 leaves the bit unchanged, and reading the word has no effect on it.
- R3: Secondary status bits set on their events whatever their secondary mask bits hold.
- R4: Primary bit g (address 8, bit g) is 1 exactly when group g has a status bit set whose secondary mask bit (addresses 4 to 7, 1 = masked) is 0.
- R5: The primary status word is read-only, and writes to address 8 change nothing.
- R6: Primary bits follow the unmasked secondaries whatever the primary mask (address 9, bit g for group g, 1 = masked) holds.
- R7: `irq_n` is 0 when at least one primary bit has its primary mask bit at 0, and 1 otherwise. The output is registered, so it follows the status one clock later.
- R8: When configuration bit 0 (address 10) is 1, `irq_n` is held at 1 whatever the internal state.
- R9: Configuration bit 1 selects the drive. With 0 (push-pull), `irq_oe` is always 1. With 1 (open-drain), `irq_oe` is 1 only while `irq_n` is 0. `irq_od` reports this bit.
- R10: When an event and a write-1 clear reach the same bit in the same cycle, the bit ends up set.
- R11: Addresses above 10 read 0, and so do the unused upper bits of the primary status, primary mask and configuration words.
- R12: After reset, all status bits are 0, all secondary and primary mask bits are 1, the configuration is 0, and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| event_i | input | 32 | Event pulses; group g uses bits 8g+7 down to 8g |
| addr | input | 4 | Register word address |
| wr_en | input | 1 | Write strobe for the addressed word |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the addressed word |
| irq_n | output | 1 | Active-low interrupt request level |
| irq_oe | output | 1 | Pad drive enable (0 = released) |
| irq_od | output | 1 | Drive mode: 1 = open-drain, 0 = push-pull |

## Verification
The assertions assume that event pulses and register writes are synchronous to `clk`. They also assume that events stay inside the declared group width, so each pulse lands on exactly one status bit. The assertions for registered pin timing compare against the previous cycle's primary and mask state, and they rely on reset having initialised that state.

The stimulus changes inputs only on the falling clock edge. It holds each event or write for exactly one cycle, and it leaves a full extra cycle before sampling the request pin. Every step therefore observes a settled state.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    typedef enum logic [1:0] {
        PIN_IDLE   = 2'd0,
        PIN_ACTIVE = 2'd1,
        PIN_GATED  = 2'd2
    } pin_state_e;

    localparam int CFG_GMASK_BIT = 0;
    localparam int CFG_OD_BIT    = 1;
    localparam int CFG_WIDTH     = 2;
endpackage

// File: rtl/irq_group.sv
module irq_group #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] ev_i,
    input  logic [WIDTH-1:0] clr_i,
    input  logic             mask_we_i,
    input  logic [WIDTH-1:0] mask_wd_i,
    output logic [WIDTH-1:0] sts_o,
    output logic [WIDTH-1:0] mask_o,
    output logic             prim_o
);
    logic [WIDTH-1:0] sts_q;
    logic [WIDTH-1:0] mask_q;

    // Set has priority over a simultaneous write-1 clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q <= '0;
        end else begin
            sts_q <= (sts_q & ~clr_i) | ev_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (mask_we_i) begin
            mask_q <= mask_wd_i;
        end
    end

    always_comb begin
        prim_o = |(sts_q & ~mask_q);
    end

    assign sts_o  = sts_q;
    assign mask_o = mask_q;

    // R1: a set bit that was not cleared stays set.
    assert_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sts_q & $past(sts_q & ~clr_i)) == $past(sts_q & ~clr_i)));

    // R10 and R3: every pulsed bit is set next cycle, whatever the mask or clear.
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_i) |=> ((sts_q & $past(ev_i)) == $past(ev_i)));

    // R2: a bit only falls when a clear was written to it.
    assert_clear_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(sts_q) & ~sts_q) & ~$past(clr_i)) == '0));
endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
    import irq_agg_pkg::*;
#(
    parameter int NUM_GROUPS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_GROUPS-1:0] prim_i,
    input  logic [NUM_GROUPS-1:0] pmask_i,
    input  logic                  gmask_i,
    input  logic                  od_i,
    output logic                  irq_n_o,
    output logic                  irq_oe_o
);
    pin_state_e state_q, state_d;
    logic       req;

    assign req = |(prim_i & ~pmask_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIN_IDLE: begin
                if (gmask_i)  state_d = PIN_GATED;
                else if (req) state_d = PIN_ACTIVE;
            end
            PIN_ACTIVE: begin
                if (gmask_i)   state_d = PIN_GATED;
                else if (!req) state_d = PIN_IDLE;
            end
            PIN_GATED: begin
                if (!gmask_i) state_d = req ? PIN_ACTIVE : PIN_IDLE;
            end
            default: state_d = PIN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PIN_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_n_o  = 1'b1;
        irq_oe_o = !od_i;
        unique case (state_q)
            PIN_IDLE:   begin irq_n_o = 1'b1; irq_oe_o = !od_i; end
            PIN_ACTIVE: begin irq_n_o = 1'b0; irq_oe_o = 1'b1;  end
            PIN_GATED:  begin irq_n_o = 1'b1; irq_oe_o = !od_i; end
            default:    begin irq_n_o = 1'b1; irq_oe_o = !od_i; end
        endcase
    end

    // R7: the pin asserts only if an enabled primary was set a cycle earlier.
    assert_low_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n_o |-> $past(req && !gmask_i));

    // R7: an enabled request with no global mask asserts the pin one cycle later.
    assert_req_raises_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !gmask_i) |=> !irq_n_o);

    // R8: the global mask holds the pin deasserted.
    assert_gmask_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        gmask_i |=> irq_n_o);

    // R9: open-drain drives only when low; push-pull always drives.
    assert_od_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (od_i && irq_n_o) |-> !irq_oe_o);
    assert_pp_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !od_i |-> irq_oe_o);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NUM_GROUPS  = 4,
    parameter int GROUP_WIDTH = 8,
    parameter int ADDR_W      = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_GROUPS*GROUP_WIDTH-1:0] event_i,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic                              wr_en,
    input  logic [GROUP_WIDTH-1:0]            wr_data,
    output logic [GROUP_WIDTH-1:0]            rd_data,
    output logic                              irq_n,
    output logic                              irq_oe,
    output logic                              irq_od
);
    localparam int DATA_W     = GROUP_WIDTH;
    localparam int SMASK_BASE = NUM_GROUPS;
    localparam int PRIM_ADDR  = 2 * NUM_GROUPS;
    localparam int PMASK_ADDR = PRIM_ADDR + 1;
    localparam int CFG_ADDR   = PRIM_ADDR + 2;

    logic [GROUP_WIDTH-1:0] sts_arr  [NUM_GROUPS];
    logic [GROUP_WIDTH-1:0] smask_arr[NUM_GROUPS];
    logic [NUM_GROUPS-1:0]  prim;
    logic [NUM_GROUPS-1:0]  pmask_q;
    logic [CFG_WIDTH-1:0]   cfg_q;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic [GROUP_WIDTH-1:0] clr;
        logic                   mwe;
        assign clr = (wr_en && addr == ADDR_W'(g)) ? wr_data : '0;
        assign mwe = wr_en && (addr == ADDR_W'(SMASK_BASE + g));

        irq_group #(.WIDTH(GROUP_WIDTH)) u_grp (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev_i     (event_i[g*GROUP_WIDTH +: GROUP_WIDTH]),
            .clr_i    (clr),
            .mask_we_i(mwe),
            .mask_wd_i(wr_data),
            .sts_o    (sts_arr[g]),
            .mask_o   (smask_arr[g]),
            .prim_o   (prim[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pmask_q <= '1;
            cfg_q   <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_W'(PMASK_ADDR)) pmask_q <= wr_data[NUM_GROUPS-1:0];
            if (addr == ADDR_W'(CFG_ADDR))   cfg_q   <= wr_data[CFG_WIDTH-1:0];
        end
    end

    always_comb begin
        rd_data = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (addr == ADDR_W'(g))              rd_data = sts_arr[g];
            if (addr == ADDR_W'(SMASK_BASE + g)) rd_data = smask_arr[g];
        end
        if (addr == ADDR_W'(PRIM_ADDR))  rd_data = DATA_W'(prim);
        if (addr == ADDR_W'(PMASK_ADDR)) rd_data = DATA_W'(pmask_q);
        if (addr == ADDR_W'(CFG_ADDR))   rd_data = DATA_W'(cfg_q);
    end

    irq_pin_ctrl #(.NUM_GROUPS(NUM_GROUPS)) u_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .prim_i  (prim),
        .pmask_i (pmask_q),
        .gmask_i (cfg_q[CFG_GMASK_BIT]),
        .od_i    (cfg_q[CFG_OD_BIT]),
        .irq_n_o (irq_n),
        .irq_oe_o(irq_oe)
    );

    assign irq_od = cfg_q[CFG_OD_BIT];

    // R11: unmapped addresses read zero.
    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(addr) > CFG_ADDR) |-> (rd_data == '0));

    // R5: a write to the primary word leaves the primary mask and configuration alone.
    assert_prim_ro_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(PRIM_ADDR)) |=> ($stable(pmask_q) && $stable(cfg_q)));
endmodule

// File: tb/sim_irq_aggregator.sv
`timescale 1ns/1ps
module sim_irq_aggregator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] event_i = '0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        irq_n, irq_oe, irq_od;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    irq_aggregator u0 (
        .clk(clk), .rst_n(rst_n), .event_i(event_i), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .irq_n(irq_n), .irq_oe(irq_oe), .irq_od(irq_od)
    );

    // Vector layout: [31] op (0 write, 1 event), [27:24] addr/group,
    // [23:16] data, [15:12] check address, [11:4] expected read, [0] expected irq_n.
    localparam int NV = 13;
    localparam logic [31:0] VEC [NV] = '{
        {1'b1,3'd0,4'd0, 8'h05,4'd0, 8'h05,3'd0,1'b1}, // R1 R3 masked bits still latch
        {1'b0,3'd0,4'd8, 8'hFF,4'd8, 8'h00,3'd0,1'b1}, // R5 primary write ignored
        {1'b0,3'd0,4'd4, 8'hFE,4'd8, 8'h01,3'd0,1'b1}, // R4 R6 primary follows, pin masked
        {1'b0,3'd0,4'd9, 8'h0E,4'd9, 8'h0E,3'd0,1'b0}, // R7 enable primary 0
        {1'b0,3'd0,4'd0, 8'h00,4'd0, 8'h05,3'd0,1'b0}, // R2 writing zero keeps bits
        {1'b0,3'd0,4'd10,8'h01,4'd10,8'h01,3'd0,1'b1}, // R8 global mask
        {1'b0,3'd0,4'd10,8'h00,4'd10,8'h00,3'd0,1'b0}, // R8 unmask again
        {1'b0,3'd0,4'd0, 8'h01,4'd0, 8'h04,3'd0,1'b1}, // R2 write one clears
        {1'b1,3'd0,4'd3, 8'h80,4'd3, 8'h80,3'd0,1'b1}, // R1 group 3 event
        {1'b0,3'd0,4'd7, 8'h7F,4'd8, 8'h08,3'd0,1'b1}, // R6 primary 3 up, still pin masked
        {1'b0,3'd0,4'd9, 8'h00,4'd8, 8'h08,3'd0,1'b0}, // R7 all primaries enabled
        {1'b0,3'd0,4'd3, 8'h80,4'd3, 8'h00,3'd0,1'b1}, // R2 R7 clear drops pin
        {1'b0,3'd0,4'd11,8'hFF,4'd11,8'h00,3'd0,1'b1}  // R11 unmapped reads zero
    };

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic step(input bit is_ev, input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        if (is_ev) event_i[a[1:0]*8 +: 8] = d;
        else begin addr = a; wr_data = d; wr_en = 1'b1; end
        @(negedge clk);
        event_i = '0; wr_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog got=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset values
        addr = 4'd0;  #1 check("R12 status", rd_data, 8'h00);
        addr = 4'd5;  #1 check("R12 smask", rd_data, 8'hFF);
        addr = 4'd9;  #1 check("R12 pmask R11", rd_data, 8'h0F);
        addr = 4'd10; #1 check("R12 cfg", rd_data, 8'h00);
        check("R12 irq_n", {7'd0, irq_n}, 8'h01);
        check("R9 pp oe", {7'd0, irq_oe}, 8'h01);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][31], VEC[i][27:24], VEC[i][23:16]);
            addr = VEC[i][15:12];
            #1;
            check($sformatf("vec%0d read", i), rd_data, VEC[i][11:4]);
            check($sformatf("vec%0d irq_n R7", i), {7'd0, irq_n}, {7'd0, VEC[i][0]});
        end

        // R10 set and clear on the same bit in one cycle
        @(negedge clk);
        event_i[8] = 1'b1; addr = 4'd1; wr_data = 8'h01; wr_en = 1'b1;
        @(negedge clk);
        event_i = '0; wr_en = 1'b0;
        #1 check("R10 set wins", rd_data, 8'h01);
        // R2 reading does not clear
        @(negedge clk);
        #1 check("R2 read keeps", rd_data, 8'h01);

        // R9 open-drain idle: released
        step(1'b0, 4'd10, 8'h02);
        addr = 4'd10; #1 check("R9 cfg read", rd_data, 8'h02);
        check("R9 od flag", {7'd0, irq_od}, 8'h01);
        check("R9 od idle irq_n", {7'd0, irq_n}, 8'h01);
        check("R9 od idle released", {7'd0, irq_oe}, 8'h00);
        // R9 open-drain asserted: driven low
        step(1'b0, 4'd5, 8'hFE);
        addr = 4'd8; #1 check("R4 primary 1", rd_data, 8'h02);
        check("R9 od active irq_n", {7'd0, irq_n}, 8'h00);
        check("R9 od active oe", {7'd0, irq_oe}, 8'h01);
        // R8 global mask in open-drain releases the pin
        step(1'b0, 4'd10, 8'h03);
        check("R8 gated irq_n", {7'd0, irq_n}, 8'h01);
        check("R8 gated oe R9", {7'd0, irq_oe}, 8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule